// File: doc/BRIEF.md
# E1 Frame Multiplexer

This block assembles 32-timeslot PCM frames of 256 bits and shifts them out as a single serial bitstream. Thirty payload channels each present one 8-bit sample on a wide parallel input bus. A synchronization byte and a signaling byte occupy the two reserved timeslots. Each high cycle of a bit-clock enable sends one bit. At the nominal 2.048 Mbit/s line rate this gives one frame per 125 µs, and each channel runs at 64 kbit/s.

The block takes a snapshot of every sample and of both reserved bytes as it sends the last bit of a frame. The next frame is therefore sent from stable data, even if the inputs change while it is on the line. For the serial bit currently on the line, the block reports its timeslot and its bit position. It also raises a one-cycle strobe on the first bit of each frame. Line coding, CRC multiframing and the line interface are handled by other blocks.

Top module: `e1_frame_mux`

## Requirements
- R1: While `rst_n` is low and after its release, before any enable, `ser_out` is 1, `frame_start` is 0, `slot_idx` is 0 and `bit_idx` is 7. The internal snapshot is cleared to zero by reset.
- R2: Consecutive `frame_start` pulses are exactly 256 enabled bits apart.
- R3: Timeslot 0 carries `sync_byte` and timeslot 16 carries `sig_byte`.
- R4: Payload channel k sits in `ch_data[8k+7:8k]`. Channels 0 to 14 go to timeslots 1 to 15, and channels 15 to 29 go to timeslots 17 to 31, in ascending order.
- R5: Each timeslot is sent most significant bit first. `bit_idx` counts down 7, 6, …, 0 with the bits.
- R6: Outputs change only on clock edges where `bit_en` is high. On other edges `ser_out`, `slot_idx` and `bit_idx` hold their values and `frame_start` is 0.
- R7: `frame_start` is high for exactly one cycle, together with the bit shown as timeslot 0, bit 7.
- R8: All inputs are captured on the edge that sends bit 0 of timeslot 31. Input changes at any other time during a frame do not affect the bits sent until that capture.
- R9: Until the first enable after reset, the snapshot reloads from the inputs on every clock edge. The first frame therefore carries the input values present at the last edge before the first enable.
- R10: `slot_idx` steps 0, 1, …, 31 and wraps to 0 after bit 0 of timeslot 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one serial bit per high cycle |
| ch_data | input | 240 | Thirty payload samples, channel k at bits 8k+7:8k |
| sync_byte | input | 8 | Byte for the synchronization timeslot |
| sig_byte | input | 8 | Byte for the signaling timeslot |
| ser_out | output | 1 | Serial line bit |
| frame_start | output | 1 | One-cycle strobe with the first bit of a frame |
| slot_idx | output | 5 | Timeslot of the bit on `ser_out` |
| bit_idx | output | 3 | Bit position of the bit on `ser_out` |

## Verification
The bench drives continuous and gapped enable patterns. A mapping error that moves the reserved bytes or skips timeslot 16 shows up as a wrong payload byte in slot 17 or slot 31. The bench changes inputs in the middle of a frame, so a snapshot taken at the wrong moment, or a serial path fed from the live inputs, leaks the new values early. It also changes the sync byte one edge before the first enable, so a design that does not track the inputs while idle sends a stale or zero first frame. A second reset is released with the enable already high; this exposes a counter that skips bit 7 or a strobe that fires on the wrong bit.

// File: rtl/e1_mux_pkg.sv
// Package: default frame geometry shared by the frame multiplexer modules.
// Assumes the synchronization slot is the first slot of the frame.
package e1_mux_pkg;
    localparam int E1_SLOTS     = 32;
    localparam int E1_SLOT_BITS = 8;
    localparam int E1_SYNC_SLOT = 0;
    localparam int E1_SIG_SLOT  = 16;
endpackage

// File: rtl/e1_slot_timer.sv
// Slot timer: tracks which timeslot and bit is sent next.
// Bits count down from SLOT_BITS-1 to 0, and slots wrap after SLOTS-1.
// Assumes step is a single-cycle qualifier sampled on each clock edge.
module e1_slot_timer #(
    parameter int SLOTS     = e1_mux_pkg::E1_SLOTS,
    parameter int SLOT_BITS = e1_mux_pkg::E1_SLOT_BITS,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [SLOT_W-1:0] slot_q,
    output logic [BIT_W-1:0]  bit_q,
    output logic              first_bit,
    output logic              last_bit,
    output logic              idle_q
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(SLOT_BITS - 1);

    // Purpose: advance the bit position and the slot position on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= TOP_BIT;
        end else if (step) begin
            if (bit_q == '0) begin
                bit_q  <= TOP_BIT;
                slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
            end else begin
                bit_q <= bit_q - 1'b1;
            end
        end
    end

    // Purpose: remember that no step has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    idle_q <= 1'b1;
        else if (step) idle_q <= 1'b0;
    end

    // Purpose: decode the first and last bit positions of a frame.
    always_comb begin
        first_bit = (slot_q == '0) && (bit_q == TOP_BIT);
        last_bit  = (slot_q == LAST_SLOT) && (bit_q == '0);
    end
endmodule

// File: rtl/e1_frame_buffer.sv
// Frame buffer: places the sync byte, the signaling byte and the payload
// samples into their timeslots and holds the whole frame while load is low.
// Assumes SYNC_SLOT < SIG_SLOT. Payload fills the remaining slots in order.
module e1_frame_buffer #(
    parameter int SLOTS     = e1_mux_pkg::E1_SLOTS,
    parameter int SLOT_BITS = e1_mux_pkg::E1_SLOT_BITS,
    parameter int SYNC_SLOT = e1_mux_pkg::E1_SYNC_SLOT,
    parameter int SIG_SLOT  = e1_mux_pkg::E1_SIG_SLOT,
    localparam int CHANNELS = SLOTS - 2,
    localparam int FRAME_W  = SLOTS * SLOT_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CHANNELS*SLOT_BITS-1:0] ch_data,
    input  logic [SLOT_BITS-1:0]          sync_byte,
    input  logic [SLOT_BITS-1:0]          sig_byte,
    output logic [FRAME_W-1:0]            frame_q
);
    logic [FRAME_W-1:0] frame_next;

    // Purpose: route each input byte to its timeslot position.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s == SYNC_SLOT) begin : g_sync
            assign frame_next[s*SLOT_BITS +: SLOT_BITS] = sync_byte;
        end else if (s == SIG_SLOT) begin : g_sig
            assign frame_next[s*SLOT_BITS +: SLOT_BITS] = sig_byte;
        end else begin : g_pay
            localparam int CH = s - ((s > SYNC_SLOT) ? 1 : 0) - ((s > SIG_SLOT) ? 1 : 0);
            assign frame_next[s*SLOT_BITS +: SLOT_BITS] = ch_data[CH*SLOT_BITS +: SLOT_BITS];
        end
    end

    // Purpose: capture the assembled frame when load is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)    frame_q <= '0;
        else if (load) frame_q <= frame_next;
    end
endmodule

// File: rtl/e1_bit_serializer.sv
// Bit serializer: picks the addressed bit of the held frame and registers it
// together with its slot/bit position and the frame-start strobe.
// Assumes slot_sel < SLOTS. Outputs hold between steps and the strobe clears.
module e1_bit_serializer #(
    parameter int SLOTS     = e1_mux_pkg::E1_SLOTS,
    parameter int SLOT_BITS = e1_mux_pkg::E1_SLOT_BITS,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS),
    localparam int FRAME_W  = SLOTS * SLOT_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [SLOT_W-1:0]  slot_sel,
    input  logic [BIT_W-1:0]   bit_sel,
    input  logic               first_bit,
    input  logic [FRAME_W-1:0] frame_q,
    output logic               ser_out,
    output logic               frame_start,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic [BIT_W-1:0]   bit_idx
);
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(SLOT_BITS - 1);

    logic [SLOT_BITS-1:0] cur_byte;
    logic                 cur_bit;

    // Purpose: select the current byte and the current bit within it.
    always_comb begin
        cur_byte = frame_q[int'(slot_sel)*SLOT_BITS +: SLOT_BITS];
        cur_bit  = cur_byte[bit_sel];
    end

    // Purpose: register the line bit and its position on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out  <= 1'b1;
            slot_idx <= '0;
            bit_idx  <= TOP_BIT;
        end else if (step) begin
            ser_out  <= cur_bit;
            slot_idx <= slot_sel;
            bit_idx  <= bit_sel;
        end
    end

    // Purpose: pulse the frame-start strobe for one cycle on the first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= step && first_bit;
    end
endmodule

// File: rtl/e1_frame_mux.sv
// E1 frame multiplexer top: a timer, a frame buffer and a serializer.
// The buffer reloads while idle after reset and on the last bit of a frame.
// Assumes bit_en is synchronous to clk.
module e1_frame_mux #(
    parameter int SLOTS     = e1_mux_pkg::E1_SLOTS,
    parameter int SLOT_BITS = e1_mux_pkg::E1_SLOT_BITS,
    parameter int SYNC_SLOT = e1_mux_pkg::E1_SYNC_SLOT,
    parameter int SIG_SLOT  = e1_mux_pkg::E1_SIG_SLOT,
    localparam int CHANNELS = SLOTS - 2,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS),
    localparam int FRAME_W  = SLOTS * SLOT_BITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_en,
    input  logic [CHANNELS*SLOT_BITS-1:0] ch_data,
    input  logic [SLOT_BITS-1:0]          sync_byte,
    input  logic [SLOT_BITS-1:0]          sig_byte,
    output logic                          ser_out,
    output logic                          frame_start,
    output logic [SLOT_W-1:0]             slot_idx,
    output logic [BIT_W-1:0]              bit_idx
);
    logic [SLOT_W-1:0]  slot_q;
    logic [BIT_W-1:0]   bit_q;
    logic               first_bit;
    logic               last_bit;
    logic               idle_q;
    logic               load;
    logic [FRAME_W-1:0] frame_q;

    // Purpose: decide when the frame buffer takes a new snapshot.
    always_comb load = (idle_q && !bit_en) || (bit_en && last_bit);

    e1_slot_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .step(bit_en),
        .slot_q(slot_q), .bit_q(bit_q),
        .first_bit(first_bit), .last_bit(last_bit), .idle_q(idle_q)
    );

    e1_frame_buffer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS),
                      .SYNC_SLOT(SYNC_SLOT), .SIG_SLOT(SIG_SLOT)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ch_data(ch_data), .sync_byte(sync_byte), .sig_byte(sig_byte),
        .frame_q(frame_q)
    );

    e1_bit_serializer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ser (
        .clk(clk), .rst_n(rst_n), .step(bit_en),
        .slot_sel(slot_q), .bit_sel(bit_q), .first_bit(first_bit),
        .frame_q(frame_q),
        .ser_out(ser_out), .frame_start(frame_start),
        .slot_idx(slot_idx), .bit_idx(bit_idx)
    );
endmodule

// File: rtl/e1_frame_mux_chk.sv
// Checker: port-level timing properties of the frame multiplexer.
// Keeps its own count of enabled bits between frame strobes.
module e1_frame_mux_chk #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              ser_out,
    input logic              frame_start,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [BIT_W-1:0]  bit_idx
);
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(SLOT_BITS - 1);

    logic started;
    logic seen_fs;
    int   bits_since;

    // Purpose: note the first enable and the first strobe since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            seen_fs <= 1'b0;
        end else begin
            if (bit_en)      started <= 1'b1;
            if (frame_start) seen_fs <= 1'b1;
        end
    end

    // Purpose: count enabled bits since the last observed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)           bits_since <= 0;
        else if (frame_start) bits_since <= bit_en ? 1 : 0;
        else if (bit_en)      bits_since <= bits_since + 1;
    end

    // R6
    hold_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(ser_out) && $stable(slot_idx) && $stable(bit_idx) && !frame_start));

    // R7
    strobe_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (slot_idx == '0 && bit_idx == TOP_BIT));

    // R5
    bit_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && bit_en && bit_idx != '0) |=> (bit_idx == $past(bit_idx) - 1'b1));

    // R10
    slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && bit_en && bit_idx == '0) |=> (slot_idx == SLOT_W'($past(slot_idx) + 1'b1)));

    // R2
    frame_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_fs) |-> (bits_since == FRAME_BITS));
endmodule

bind e1_frame_mux e1_frame_mux_chk #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_out(ser_out),
    .frame_start(frame_start), .slot_idx(slot_idx), .bit_idx(bit_idx)
);

// File: tb/e1_frame_mux_test.sv
`timescale 1ns/1ps
module e1_frame_mux_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         bit_en;
    logic [239:0] ch_data;
    logic [7:0]   sync_byte, sig_byte;
    logic         ser_out, frame_start;
    logic [4:0]   slot_idx;
    logic [2:0]   bit_idx;

    int checks = 0, fails = 0;
    bit done = 0, cmp_on = 0;

    always #2.5 clk = ~clk;

    e1_frame_mux uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ch_data(ch_data),
        .sync_byte(sync_byte), .sig_byte(sig_byte), .ser_out(ser_out),
        .frame_start(frame_start), .slot_idx(slot_idx), .bit_idx(bit_idx)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic fill(int seed);
        for (int k = 0; k < 30; k++) ch_data[k*8 +: 8] = 8'(seed + k * 37);
    endtask

    // Expected byte of a timeslot from the requirement mapping (R3, R4)
    function automatic logic [7:0] slot_val(int s);
        if (s == 0)  return sync_byte;
        if (s == 16) return sig_byte;
        return ch_data[((s < 16) ? s - 1 : s - 2)*8 +: 8];
    endfunction

    // Reference model: frame snapshot plus a bit position 0..255
    logic [7:0] snap [32];
    int         pos;
    bit         idle;
    logic       e_ser, e_fs;
    int         e_slot, e_bit;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_ser <= 1; e_fs <= 0; e_slot <= 0; e_bit <= 7; pos <= 0; idle <= 1;
            for (int s = 0; s < 32; s++) snap[s] <= 8'h00;
        end else if (bit_en) begin
            e_ser  <= snap[pos / 8][7 - pos % 8];
            e_fs   <= (pos == 0);
            e_slot <= pos / 8;
            e_bit  <= 7 - pos % 8;
            pos    <= (pos + 1) % 256;
            idle   <= 0;
            if (pos == 255) for (int s = 0; s < 32; s++) snap[s] <= slot_val(s);
        end else begin
            e_fs <= 0;
            if (idle) for (int s = 0; s < 32; s++) snap[s] <= slot_val(s);
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R3/R4/R5/R8/R9 ser_out", int'(ser_out), int'(e_ser));
            chk("R2/R7 frame_start", int'(frame_start), int'(e_fs));
            chk("R10/R6 slot_idx", int'(slot_idx), e_slot);
            chk("R5/R6 bit_idx", int'(bit_idx), e_bit);
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    logic [7:0] cap [32];
    logic [7:0] x_sync, x_sig;
    logic [239:0] x_ch;

    initial begin
        rst_n = 0; bit_en = 0; sync_byte = 8'h1B; sig_byte = 8'hA5; fill(3);
        repeat (4) @(negedge clk);
        // R1 reset values
        chk("R1 ser_out", int'(ser_out), 1);
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 slot_idx", int'(slot_idx), 0);
        chk("R1 bit_idx", int'(bit_idx), 7);
        rst_n = 1; cmp_on = 1;
        repeat (3) @(negedge clk);
        chk("R1 ser_out idle", int'(ser_out), 1);
        sync_byte = 8'h9C;               // R9: last value before first enable
        @(negedge clk);
        x_sync = sync_byte; x_sig = sig_byte; x_ch = ch_data;
        for (int b = 0; b < 256; b++) begin
            bit_en = 1;
            if (b == 100) begin fill(90); sig_byte = 8'h3C; end  // R8 mid-frame change
            @(negedge clk);
            cap[b / 8] = {cap[b / 8][6:0], ser_out};
        end
        bit_en = 0;
        chk("R3 R9 sync slot", int'(cap[0]), int'(x_sync));
        chk("R3 R8 signaling slot", int'(cap[16]), int'(x_sig));
        chk("R4 ch0 slot1", int'(cap[1]), int'(x_ch[7:0]));
        chk("R4 R8 ch14 slot15", int'(cap[15]), int'(x_ch[14*8 +: 8]));
        chk("R4 R8 ch15 slot17", int'(cap[17]), int'(x_ch[15*8 +: 8]));
        chk("R4 R8 ch29 slot31", int'(cap[31]), int'(x_ch[29*8 +: 8]));
        // Gapped enable pattern with input changes at odd moments
        for (int i = 0; i < 2400; i++) begin
            bit_en = ((i % 3) != 1) || ((i % 7) == 0);
            if (i == 700)  begin fill(150); sync_byte = 8'h55; end
            if (i == 1500) begin fill(211); sig_byte = 8'hE7; end
            @(negedge clk);
        end
        bit_en = 0;
        // Second reset, released with enable already high
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 ser_out re-reset", int'(ser_out), 1);
        chk("R1 slot_idx re-reset", int'(slot_idx), 0);
        bit_en = 1; rst_n = 1;
        repeat (600) @(negedge clk);
        bit_en = 0;
        repeat (4) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule